// File: doc/BRIEF.md
# Bidirectional Handshake Parallel Port

This block is one 8-bit parallel port channel that moves bytes both ways over a single shared peripheral data bus. Two strobe/ready pairs control it. The output pair (`out_rdy`, `out_stb_n`) governs bytes the CPU sends to the peripheral. The input pair (`in_rdy`, `in_stb_n`) governs bytes the peripheral sends to the CPU. The port drives the shared bus only while the peripheral holds the output strobe low. At every other time the bus is released, so the peripheral can place its own data there.

On the CPU side there is a write strobe with a data byte, and a read strobe that acknowledges the input byte. The input byte is always visible on `cpu_rdata`. The ready lines double as status flags. Each half has its own interrupt enable and raises its own one-cycle request.

Both peripheral strobes are asynchronous to the system clock. The bus byte passes through the same two-flop synchronizer as the strobes, so each captured byte lines up with the strobe level seen in the same cycle. Because of this, the peripheral may withdraw its input data as soon as the input strobe rises, with zero hold time.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, `out_rdy` is 0, `in_rdy` is 1, `cpu_rdata` is 8'h00, both interrupt outputs are 0 and the port does not drive `pdata`.
- R2: A CPU write while no output transfer is in progress loads `cpu_wdata` into the output register and raises `out_rdy` on the next clock edge.
- R3: While `out_stb_n` is low, `pdata` carries the output register. While it is high, the port releases the bus, and a byte the peripheral drives there can be captured.
- R4: The rising edge of `out_stb_n` clears `out_rdy`. When `out_irq_en` is 1 it also raises `out_irq` for exactly one cycle.
- R5: From the synchronized falling edge of `out_stb_n` until its rising edge, CPU writes are ignored, so the byte on the bus stays stable through the strobe's rising edge.
- R6: The input register follows the bus while `in_stb_n` is low and keeps the last byte present before the strobe rose. A bus change made at the same moment as the rising edge is not captured.
- R7: The rising edge of `in_stb_n` marks the input register full and drops `in_rdy`. When `in_irq_en` is 1 it also raises `in_irq` for exactly one cycle.
- R8: A CPU read (`cpu_rd`) while the input register is full sets `in_rdy` again on the next edge.
- R9: If a CPU read and the synchronized rising edge of `in_stb_n` land in the same cycle, the new byte wins: `in_rdy` stays 0.
- R10: With an interrupt enable at 0, that half completes its transfer but never pulses its interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe, loads output register |
| cpu_wdata | input | 8 | Byte to send |
| cpu_rd | input | 1 | Read acknowledge of the input byte |
| cpu_rdata | output | 8 | Input register contents |
| out_irq_en | input | 1 | Output-side interrupt enable |
| in_irq_en | input | 1 | Input-side interrupt enable |
| out_irq | output | 1 | One-cycle output-done request |
| in_irq | output | 1 | One-cycle input-arrived request |
| pdata | inout | 8 | Shared peripheral data bus |
| out_rdy | output | 1 | Output byte waiting for the peripheral |
| out_stb_n | input | 1 | Peripheral output strobe, active low |
| in_rdy | output | 1 | Input register empty, ready for a byte |
| in_stb_n | input | 1 | Peripheral input strobe, active low |

## Verification
Two functions can fall in the same cycle: the CPU acknowledging the input byte, and a fresh input strobe edge marking the register full. The bench provokes this by releasing `in_stb_n` and then pulsing `cpu_rd` exactly two edges later. That is the edge at which the synchronized rise takes effect. The bench then judges the outcome by `in_rdy` staying low. A second overlap is a CPU write during a held output strobe. The bench judges that one by the bus byte not changing.

// File: rtl/bidir_hs_pkg.sv
package bidir_hs_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              busy;
        logic              stb_prev;
        logic              irq;
    } out_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              stb_prev;
        logic              irq;
    } in_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int          W       = 10,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/hs_out_half.sv
module hs_out_half
    import bidir_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stb_n_s,
    input  logic              irq_en,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_o,
    output logic              irq_o
);
    out_state_t st_d, st_q;
    logic stb_fall, stb_rise;

    assign stb_fall = st_q.stb_prev & ~stb_n_s;
    assign stb_rise = ~st_q.stb_prev & stb_n_s;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_n_s;
        st_d.irq      = 1'b0;
        if (wr && !st_q.busy) begin
            st_d.data = wdata;
            st_d.rdy  = 1'b1;
        end
        if (stb_fall) begin
            st_d.busy = 1'b1;
        end
        if (stb_rise) begin
            st_d.busy = 1'b0;
            st_d.rdy  = 1'b0;
            st_d.irq  = irq_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, rdy: 1'b0, busy: 1'b0, stb_prev: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign rdy_o  = st_q.rdy;
    assign irq_o  = st_q.irq;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !st_q.busy && !stb_rise) |=> (st_q.rdy && st_q.data == $past(wdata)));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.data == $past(st_q.data)));

    // R4
    out_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);

    // R4
    out_rise_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> !st_q.rdy);
endmodule

// File: rtl/hs_in_half.sv
module hs_in_half
    import bidir_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              stb_n_s,
    input  logic [DATA_W-1:0] bus_s,
    input  logic              irq_en,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_o,
    output logic              irq_o
);
    in_state_t st_d, st_q;
    logic stb_rise;

    assign stb_rise = ~st_q.stb_prev & stb_n_s;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_n_s;
        st_d.irq      = 1'b0;
        if (!stb_n_s) begin
            st_d.data = bus_s;
        end
        if (stb_rise) begin
            st_d.full = 1'b1;
            st_d.irq  = irq_en;
        end else if (rd) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, full: 1'b0, stb_prev: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign rdy_o  = ~st_q.full;
    assign irq_o  = st_q.irq;

    // R7
    in_irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.full);

    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !stb_rise && st_q.full) |=> !st_q.full);

    // R9
    rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> st_q.full);

    // R6
    hold_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n_s |=> (st_q.data == $past(st_q.data)));
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
    import bidir_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              out_irq_en,
    input  logic              in_irq_en,
    output logic              out_irq,
    output logic              in_irq,
    inout  wire  [DATA_W-1:0] pdata,
    output logic              out_rdy,
    input  logic              out_stb_n,
    output logic              in_rdy,
    input  logic              in_stb_n
);
    localparam int SYNC_W = DATA_W + 2;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [DATA_W-1:0] out_reg;

    assign sync_in = {in_stb_n, out_stb_n, pdata};

    hs_sync #(
        .W       (SYNC_W),
        .RST_VAL ({2'b11, {DATA_W{1'b0}}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    hs_out_half u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cpu_wr),
        .wdata   (cpu_wdata),
        .stb_n_s (sync_out[DATA_W]),
        .irq_en  (out_irq_en),
        .data_o  (out_reg),
        .rdy_o   (out_rdy),
        .irq_o   (out_irq)
    );

    hs_in_half u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (cpu_rd),
        .stb_n_s (sync_out[DATA_W+1]),
        .bus_s   (sync_out[DATA_W-1:0]),
        .irq_en  (in_irq_en),
        .data_o  (cpu_rdata),
        .rdy_o   (in_rdy),
        .irq_o   (in_irq)
    );

    assign pdata = out_stb_n ? {DATA_W{1'bz}} : out_reg;
endmodule

// File: tb/bidir_hs_port_tb.sv
module bidir_hs_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       out_irq_en = 1'b1, in_irq_en = 1'b1;
    logic       out_irq, in_irq, out_rdy, in_rdy;
    logic       out_stb_n = 1'b1, in_stb_n = 1'b1;
    logic       p_en = 1'b0;
    logic [7:0] p_val = 8'h00;
    wire  [7:0] pdata;

    int tests = 0, fails = 0;
    int oirq_cnt = 0, iirq_cnt = 0;
    bit done = 1'b0;

    assign pdata = p_en ? p_val : 8'bz;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (out_irq) oirq_cnt <= oirq_cnt + 1;
        if (in_irq)  iirq_cnt <= iirq_cnt + 1;
    end

    bidir_hs_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .out_irq_en(out_irq_en),
        .in_irq_en(in_irq_en), .out_irq(out_irq), .in_irq(in_irq),
        .pdata(pdata), .out_rdy(out_rdy), .out_stb_n(out_stb_n),
        .in_rdy(in_rdy), .in_stb_n(in_stb_n)
    );

    // {byte to send, byte to receive}
    localparam logic [15:0] VEC [4] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E};

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] b);
        cpu_wr = 1'b1; cpu_wdata = b;
        cyc(1);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read();
        cpu_rd = 1'b1;
        cyc(1);
        cpu_rd = 1'b0;
    endtask

    task automatic in_xfer(input logic [7:0] b);
        p_en = 1'b1; p_val = b; in_stb_n = 1'b0;
        cyc(4);
        in_stb_n = 1'b1; p_en = 1'b0;
        cyc(4);
    endtask

    initial begin
        cyc(2);
        // R1 reset state
        chk("R1 out_rdy", out_rdy, 0);
        chk("R1 in_rdy", in_rdy, 1);
        chk("R1 rdata", cpu_rdata, 0);
        chk("R1 irq", {out_irq, in_irq}, 0);
        rst_n = 1'b1;
        cyc(2);

        foreach (VEC[i]) begin
            int oc, ic;
            oc = oirq_cnt; ic = iirq_cnt;
            cpu_write(VEC[i][15:8]);
            chk("R2 out_rdy set", out_rdy, 1);
            out_stb_n = 1'b0;
            #1;
            chk("R3 bus drive", pdata, VEC[i][15:8]);
            cyc(4);
            out_stb_n = 1'b1;
            cyc(4);
            chk("R4 out_rdy clear", out_rdy, 0);
            chk("R4 out_irq pulse", oirq_cnt - oc, 1);
            // R3 bus released: peripheral byte captured
            in_xfer(VEC[i][7:0]);
            chk("R3 R6 input byte", cpu_rdata, VEC[i][7:0]);
            chk("R7 in_rdy low", in_rdy, 0);
            chk("R7 in_irq pulse", iirq_cnt - ic, 1);
            cpu_read();
            chk("R8 in_rdy set", in_rdy, 1);
        end

        // R5 write during held strobe ignored
        cpu_write(8'h11);
        out_stb_n = 1'b0;
        cyc(4);
        cpu_write(8'h22);
        #1;
        chk("R5 bus stable", pdata, 8'h11);
        out_stb_n = 1'b1;
        cyc(4);
        chk("R5 out_rdy after", out_rdy, 0);
        cpu_write(8'h33);
        out_stb_n = 1'b0;
        #1;
        chk("R2 next write", pdata, 8'h33);
        cyc(4);
        out_stb_n = 1'b1;
        cyc(4);

        // R6 zero hold: data changes with the strobe rise
        p_en = 1'b1; p_val = 8'h5A; in_stb_n = 1'b0;
        cyc(4);
        in_stb_n = 1'b1; p_val = 8'hC3;
        cyc(4);
        p_en = 1'b0;
        chk("R6 zero hold", cpu_rdata, 8'h5A);
        cpu_read();

        // R9 read in the same cycle as the synchronized rise
        p_en = 1'b1; p_val = 8'h96; in_stb_n = 1'b0;
        cyc(4);
        in_stb_n = 1'b1;
        cyc(2);
        cpu_rd = 1'b1;
        cyc(1);
        cpu_rd = 1'b0; p_en = 1'b0;
        cyc(2);
        chk("R9 rise wins", in_rdy, 0);
        chk("R9 byte", cpu_rdata, 8'h96);
        cpu_read();

        // R10 interrupts disabled
        begin
            int oc, ic;
            out_irq_en = 1'b0; in_irq_en = 1'b0;
            oc = oirq_cnt; ic = iirq_cnt;
            cpu_write(8'h44);
            out_stb_n = 1'b0; cyc(4); out_stb_n = 1'b1; cyc(4);
            in_xfer(8'h77);
            chk("R10 out no irq", oirq_cnt - oc, 0);
            chk("R10 in no irq", iirq_cnt - ic, 0);
            chk("R10 out_rdy done", out_rdy, 0);
            chk("R10 in done", in_rdy, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule